// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Event Detection

The block controls a bank of general-purpose pins (54 by default) through a plain 32-bit register bus of separate read and write strobes. Each pin carries a 3-bit function code. The code decides whether the pin floats as an input, drives a value from an internal output latch, or passes one of six alternate-function sources that arrive on wide input ports. Software never writes the output latch directly. It writes one word whose set bits raise pins and another whose set bits lower them, so no read-modify-write is needed.

Pin inputs go through a synchronizer. The synchronized values can be read back as a level word. They also feed four detector kinds (rising edge, falling edge, high level, low level), each with its own per-pin enable. A detector that fires sets a sticky per-pin status bit, and software clears that bit by writing one to it.

Addresses are byte offsets. A pin's bit in any two-word register is bit `p%32` of word `p/32`, and the second word sits 4 bytes above the first. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.

Top module: `gpio_bank`

## Requirements
- R1: After reset every function code is 000, the output latch, all detector enables and all status bits are 0, and `pad_out` and `pad_oe` are all 0.
- R2: Function words sit at offsets 0x00 to 0x14. Pin p uses bits `3*(p%10)+2 : 3*(p%10)` of the word at offset `4*(p/10)`. Bits 31:30 of every function word read 0, and the word at 0x14 holds only pins 50 to 53 in bits 11:0.
- R3: Code 000 leaves the pin undriven (`pad_oe`=0, `pad_out`=0). Code 001 drives the latch value with `pad_oe`=1.
- R4: Codes map to alternate sources as follows: 100 to source 0, 101 to 1, 110 to 2, 111 to 3, 011 to 4, 010 to 5. A pin p on source k copies `alt_out[k*54+p]` and `alt_oe[k*54+p]` to its pad.
- R5: A write to 0x1C/0x20 sets the latch bit of every pin whose data bit is 1. A write to 0x28/0x2C clears it for each data bit that is 1. Data bits that are 0 leave the latch alone. These four offsets read as 0, and the latch changes only on a bus write.
- R6: The level words at 0x34/0x38 return `pad_in` after a two-flop synchronizer. An input held for 3 cycles is visible to a read.
- R7: With the rising enable (0x4C/0x50) set, a 0-to-1 change of the synchronized input sets the pin's status bit (0x40/0x44). With the falling enable (0x58/0x5C) set, a 1-to-0 change sets it.
- R8: With the high enable (0x64/0x68) or the low enable (0x70/0x74) set, a synchronized level of 1 or of 0 respectively sets the status bit. The bit stays set after the condition and the enable are gone.
- R9: Writing 1 to a status bit clears it, and writing 0 has no effect. A detection in the same cycle as the clear leaves the bit set.
- R10: Bits for pins 54 to 63 in every two-word register read 0 and ignore writes.
- R11: A status bit never becomes set unless one of its pin's four enables was set in the previous cycle.
- R12: `bus_rdata` is 0 in every cycle that does not follow a sampled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| pad_in | input | 54 | Pin input levels |
| pad_out | output | 54 | Pin output values |
| pad_oe | output | 54 | Pin output enables |
| alt_out | input | 324 | Alternate-function outputs, source k in bits k*54 upward |
| alt_oe | input | 324 | Alternate-function output enables, same layout |

## Verification
On every cycle, the assertions check three things. The output latch moves only on bus writes. A status bit is only lost through a one written to it, and it is only gained when an enable was set. The strobe-only offsets and idle cycles return zero data. The bench scenarios cover the rest. They check the non-binary mapping from code to alternate source, using sources that differ per slice and are then inverted. They also check the field packing and reserved bits of the function words, the synchronizer latency of the level words, and each of the four detector kinds. Finally they check that a clear coinciding with a still-active high-level detection leaves the bit set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned FN_W       = 3;
   localparam int unsigned SEL_FIELDS = 10;

   localparam int unsigned OFS_FSEL = 'h00;
   localparam int unsigned OFS_SET  = 'h1C;
   localparam int unsigned OFS_CLR  = 'h28;
   localparam int unsigned OFS_LEV  = 'h34;
   localparam int unsigned OFS_EVS  = 'h40;
   localparam int unsigned OFS_RISE = 'h4C;
   localparam int unsigned OFS_FALL = 'h58;
   localparam int unsigned OFS_HIGH = 'h64;
   localparam int unsigned OFS_LOW  = 'h70;

   typedef enum logic [FN_W-1:0] {
      FN_IN   = 3'b000,
      FN_OUT  = 3'b001,
      FN_ALT5 = 3'b010,
      FN_ALT4 = 3'b011,
      FN_ALT0 = 3'b100,
      FN_ALT1 = 3'b101,
      FN_ALT2 = 3'b110,
      FN_ALT3 = 3'b111
   } fn_code_e;

   typedef struct packed {
      logic [FN_W-1:0] fn;
      logic            drive;
      logic            en_rise;
      logic            en_fall;
      logic            en_high;
      logic            en_low;
   } pin_cfg_t;

   // Source number selected by an alternate code; the order is not binary.
   function automatic logic [2:0] alt_index(input logic [FN_W-1:0] code);
      case (code)
         FN_ALT0: alt_index = 3'd0;
         FN_ALT1: alt_index = 3'd1;
         FN_ALT2: alt_index = 3'd2;
         FN_ALT3: alt_index = 3'd3;
         FN_ALT4: alt_index = 3'd4;
         FN_ALT5: alt_index = 3'd5;
         default: alt_index = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 54,
   parameter int unsigned NUM_ALT  = 6
) (
   input  logic [NUM_PINS*FN_W-1:0]    fn_flat,
   input  logic [NUM_PINS-1:0]         drive,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
   output logic [NUM_PINS-1:0]         pad_out,
   output logic [NUM_PINS-1:0]         pad_oe
);

   if (NUM_ALT != 6) begin : g_bad_alt
      $error("gpio_pin_mux: the code table defines exactly six alternate sources");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [NUM_ALT-1:0] src_o;
      logic [NUM_ALT-1:0] src_e;
      logic [FN_W-1:0]    fn;

      assign fn = fn_flat[p*FN_W +: FN_W];

      for (genvar k = 0; k < NUM_ALT; k++) begin : g_src
         assign src_o[k] = alt_out[k*NUM_PINS + p];
         assign src_e[k] = alt_oe[k*NUM_PINS + p];
      end

      always_comb begin
         pad_out[p] = 1'b0;
         pad_oe[p]  = 1'b0;
         case (fn)
            FN_IN: begin
            end
            FN_OUT: begin
               pad_out[p] = drive[p];
               pad_oe[p]  = 1'b1;
            end
            default: begin
               pad_out[p] = src_o[alt_index(fn)];
               pad_oe[p]  = src_e[alt_index(fn)];
            end
         endcase
      end
   end

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
   parameter int unsigned NUM_PINS    = 54,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   input  logic [NUM_PINS-1:0] en_rise,
   input  logic [NUM_PINS-1:0] en_fall,
   input  logic [NUM_PINS-1:0] en_high,
   input  logic [NUM_PINS-1:0] en_low,
   input  logic [NUM_PINS-1:0] evs_clr,
   output logic [NUM_PINS-1:0] level,
   output logic [NUM_PINS-1:0] evs
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_event_unit: at least two synchronizer stages are required");
   end

   logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0]                  prev_q;
   logic [NUM_PINS-1:0]                  evs_q;
   logic [NUM_PINS-1:0]                  det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   assign det = (en_rise &  level & ~prev_q)
              | (en_fall & ~level &  prev_q)
              | (en_high &  level)
              | (en_low  & ~level);

   // Detection is ORed after the clear so a coincident event wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evs_q <= '0;
      else        evs_q <= (evs_q & ~evs_clr) | det;
   end

   assign evs = evs_q;

   // R9: a status bit is lost only through a clear written to it.
   assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(evs_q) & ~$past(evs_clr)) & ~evs_q) == '0));

   // R11: a newly set bit needs one of its enables in the cycle before.
   assert_no_event_without_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evs_q & ~$past(evs_q)
                 & ~$past(en_rise | en_fall | en_high | en_low)) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 54,
   parameter int unsigned NUM_ALT     = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   input  logic [NUM_PINS-1:0]         pad_in,
   output logic [NUM_PINS-1:0]         pad_out,
   output logic [NUM_PINS-1:0]         pad_oe,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe
);

   localparam int unsigned NUM_SEL  = (NUM_PINS + SEL_FIELDS - 1) / SEL_FIELDS;
   localparam int unsigned SEL_PAD  = NUM_SEL * SEL_FIELDS;
   localparam int unsigned FLD_BITS = SEL_FIELDS * FN_W;
   localparam int unsigned PAD64    = 64 - NUM_PINS;

   if (NUM_PINS <= 32 || NUM_PINS >= 64) begin : g_bad_pins
      $error("gpio_bank: NUM_PINS must lie between 33 and 63");
   end
   if (NUM_SEL * 4 > OFS_SET) begin : g_bad_sel
      $error("gpio_bank: function words overlap the set strobe offset");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_bank: ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS*FN_W-1:0] fn_flat;
   logic [NUM_PINS-1:0]      drive_vec, rise_vec, fall_vec, high_vec, low_vec;
   logic [NUM_PINS-1:0]      evs_clr, level, evs;

   // ---------------- per-pin configuration registers ----------------
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
      localparam int unsigned WRD = p / 32;
      localparam int unsigned BIT = p % 32;
      localparam int unsigned SW  = p / SEL_FIELDS;
      localparam int unsigned SF  = (p % SEL_FIELDS) * FN_W;

      pin_cfg_t cfg_q;
      logic     hit_fn, hit_set, hit_clr, hit_rise, hit_fall, hit_high, hit_low, hit_evs;

      assign hit_fn   = bus_wr && bus_addr == ADDR_W'(OFS_FSEL + 4*SW);
      assign hit_set  = bus_wr && bus_addr == ADDR_W'(OFS_SET  + 4*WRD);
      assign hit_clr  = bus_wr && bus_addr == ADDR_W'(OFS_CLR  + 4*WRD);
      assign hit_rise = bus_wr && bus_addr == ADDR_W'(OFS_RISE + 4*WRD);
      assign hit_fall = bus_wr && bus_addr == ADDR_W'(OFS_FALL + 4*WRD);
      assign hit_high = bus_wr && bus_addr == ADDR_W'(OFS_HIGH + 4*WRD);
      assign hit_low  = bus_wr && bus_addr == ADDR_W'(OFS_LOW  + 4*WRD);
      assign hit_evs  = bus_wr && bus_addr == ADDR_W'(OFS_EVS  + 4*WRD);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= '0;
         end else begin
            if (hit_fn)                        cfg_q.fn      <= bus_wdata[SF +: FN_W];
            if (hit_set && bus_wdata[BIT])     cfg_q.drive   <= 1'b1;
            if (hit_clr && bus_wdata[BIT])     cfg_q.drive   <= 1'b0;
            if (hit_rise)                      cfg_q.en_rise <= bus_wdata[BIT];
            if (hit_fall)                      cfg_q.en_fall <= bus_wdata[BIT];
            if (hit_high)                      cfg_q.en_high <= bus_wdata[BIT];
            if (hit_low)                       cfg_q.en_low  <= bus_wdata[BIT];
         end
      end

      assign fn_flat[p*FN_W +: FN_W] = cfg_q.fn;
      assign drive_vec[p] = cfg_q.drive;
      assign rise_vec[p]  = cfg_q.en_rise;
      assign fall_vec[p]  = cfg_q.en_fall;
      assign high_vec[p]  = cfg_q.en_high;
      assign low_vec[p]   = cfg_q.en_low;
      assign evs_clr[p]   = hit_evs && bus_wdata[BIT];
   end

   // ---------------- datapath sub-blocks ----------------
   gpio_pin_mux #(
      .NUM_PINS (NUM_PINS),
      .NUM_ALT  (NUM_ALT)
   ) i_mux (
      .fn_flat  (fn_flat),
      .drive    (drive_vec),
      .alt_out  (alt_out),
      .alt_oe   (alt_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   gpio_event_unit #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in),
      .en_rise (rise_vec),
      .en_fall (fall_vec),
      .en_high (high_vec),
      .en_low  (low_vec),
      .evs_clr (evs_clr),
      .level   (level),
      .evs     (evs)
   );

   // ---------------- read path ----------------
   logic [SEL_PAD*FN_W-1:0] fn_pad;
   logic [31:0]             sel_word [NUM_SEL];
   logic [63:0]             lev64, evs64, rise64, fall64, high64, low64;
   logic [31:0]             rd_word;

   assign fn_pad = {{((SEL_PAD - NUM_PINS) * FN_W){1'b0}}, fn_flat};
   for (genvar w = 0; w < NUM_SEL; w++) begin : g_selword
      assign sel_word[w] = {{(32 - FLD_BITS){1'b0}}, fn_pad[w*FLD_BITS +: FLD_BITS]};
   end

   assign lev64  = {{PAD64{1'b0}}, level};
   assign evs64  = {{PAD64{1'b0}}, evs};
   assign rise64 = {{PAD64{1'b0}}, rise_vec};
   assign fall64 = {{PAD64{1'b0}}, fall_vec};
   assign high64 = {{PAD64{1'b0}}, high_vec};
   assign low64  = {{PAD64{1'b0}}, low_vec};

   always_comb begin
      rd_word = '0;
      if (bus_addr < ADDR_W'(4*NUM_SEL) && bus_addr[1:0] == 2'b00) begin
         rd_word = sel_word[bus_addr[4:2]];
      end else begin
         case (bus_addr)
            ADDR_W'(OFS_LEV):      rd_word = lev64[31:0];
            ADDR_W'(OFS_LEV + 4):  rd_word = lev64[63:32];
            ADDR_W'(OFS_EVS):      rd_word = evs64[31:0];
            ADDR_W'(OFS_EVS + 4):  rd_word = evs64[63:32];
            ADDR_W'(OFS_RISE):     rd_word = rise64[31:0];
            ADDR_W'(OFS_RISE + 4): rd_word = rise64[63:32];
            ADDR_W'(OFS_FALL):     rd_word = fall64[31:0];
            ADDR_W'(OFS_FALL + 4): rd_word = fall64[63:32];
            ADDR_W'(OFS_HIGH):     rd_word = high64[31:0];
            ADDR_W'(OFS_HIGH + 4): rd_word = high64[63:32];
            ADDR_W'(OFS_LOW):      rd_word = low64[31:0];
            ADDR_W'(OFS_LOW + 4):  rd_word = low64[63:32];
            default:               rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
      else             bus_rdata <= '0;
   end

   // R5: the output latch moves only in the cycle after a write strobe.
   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(drive_vec));

   // R5: strobe-only offsets return zero data.
   assert_strobe_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_SET + 4) ||
                  bus_addr == ADDR_W'(OFS_CLR) || bus_addr == ADDR_W'(OFS_CLR + 4)))
      |=> bus_rdata == '0);

   // R12: no read strobe, no read data.
   assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
   localparam int NP = 54;
   localparam int NA = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pad_in = '0;
   logic [NP-1:0]   pad_out, pad_oe;
   logic [NA*NP-1:0] alt_out = '0;
   logic [NA*NP-1:0] alt_oe = '0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_bank i_gpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .alt_out(alt_out), .alt_oe(alt_oe)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t exp_q[$];
   int  n_checks = 0;
   int  n_fail   = 0;
   logic rd_q = 1'b0;
   bit   done = 1'b0;

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one expected item per sampled read
   always @(posedge clk) rd_q <= bus_rd;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R12 unexpected read data actual=%0h expected=none", bus_rdata);
         end else begin
            rd_item_t it;
            it = exp_q.pop_front();
            check({32'h0, bus_rdata}, {32'h0, it.exp}, it.tag);
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] fld(input int p, input logic [2:0] c);
      return 32'(c) << ((p % 10) * 3);
   endfunction

   // one alternate-source case: pin p on source k
   task automatic alt_case(input int p, input int k, input string tag);
      alt_out = '0; alt_oe = '0;
      alt_out[k*NP + p] = 1'b1; alt_oe[k*NP + p] = 1'b1;
      #1;
      check({62'h0, pad_out[p], pad_oe[p]}, 64'h3, tag);
      alt_out = '1; alt_oe = '1;
      alt_out[k*NP + p] = 1'b0; alt_oe[k*NP + p] = 1'b0;
      #1;
      check({62'h0, pad_out[p], pad_oe[p]}, 64'h0, tag);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] pat;
      logic [31:0]   sel0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check({10'h0, pad_oe}, 64'h0, "R1 pad_oe after reset");
      check({10'h0, pad_out}, 64'h0, "R1 pad_out after reset");
      check({32'h0, bus_rdata}, 64'h0, "R1 rdata after reset");
      bus_read(8'h00, 32'h0, "R1 function word 0 reset");
      bus_read(8'h40, 32'h0, "R1 status word 0 reset");
      bus_read(8'h4C, 32'h0, "R1 rising enables reset");

      // R2 packing and reserved bits, R4 code table
      sel0 = fld(0, 3'b001) | fld(1, 3'b100) | fld(3, 3'b101) | fld(4, 3'b110)
           | fld(5, 3'b111) | fld(6, 3'b011) | fld(9, 3'b010);
      bus_write(8'h00, sel0 | 32'hC000_0000);
      bus_read(8'h00, sel0, "R2 function word 0 readback, bits 31:30 zero");
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_read(8'h14, 32'h0000_0FFF, "R2 last function word holds pins 50-53 only");

      alt_case(1, 0, "R4 code 100 selects source 0");
      alt_case(3, 1, "R4 code 101 selects source 1");
      alt_case(4, 2, "R4 code 110 selects source 2");
      alt_case(5, 3, "R4 code 111 selects source 3");
      alt_case(6, 4, "R4 code 011 selects source 4");
      alt_case(9, 5, "R4 code 010 selects source 5");
      alt_case(52, 3, "R4 pin 52 code 111 source 3");
      alt_out = '1; alt_oe = '1;
      @(negedge clk);

      // R3 input and output modes
      check({62'h0, pad_out[2], pad_oe[2]}, 64'h0, "R3 input pin undriven");
      check({62'h0, pad_out[0], pad_oe[0]}, 64'h1, "R3 output pin drives latch 0");

      // R5 set and clear strobes
      bus_write(8'h1C, 32'h0000_0001);
      check({62'h0, pad_out[0], pad_oe[0]}, 64'h3, "R5 set drives pin 0 high");
      bus_write(8'h28, 32'h0000_0000);
      check({63'h0, pad_out[0]}, 64'h1, "R5 clear of zeros has no effect");
      bus_write(8'h28, 32'h0000_0001);
      check({63'h0, pad_out[0]}, 64'h0, "R5 clear drives pin 0 low");
      bus_write(8'h1C, 32'h0000_0000);
      check({63'h0, pad_out[0]}, 64'h0, "R5 set of zeros has no effect");
      bus_write(8'h20, 32'hFFFF_FFFF);
      bus_write(8'h10, fld(40, 3'b001));
      check({62'h0, pad_out[40], pad_oe[40]}, 64'h3, "R5 upper word set pin 40");
      bus_write(8'h2C, 32'h0000_0100);
      check({63'h0, pad_out[40]}, 64'h0, "R5 upper word clear pin 40");
      bus_read(8'h1C, 32'h0, "R5 set word reads zero");
      bus_read(8'h2C, 32'h0, "R5 clear word reads zero");

      // R6 level readback, R11 no events without enables
      pat = 54'h15ABCD12345678;
      @(negedge clk); pad_in = pat;
      repeat (3) @(negedge clk);
      bus_read(8'h34, pat[31:0], "R6 level word 0");
      bus_read(8'h38, {10'h0, pat[53:32]}, "R6 level word 1, R10 upper bits zero");
      @(negedge clk);
      check({32'h0, bus_rdata}, 64'h0, "R12 rdata idle after read");
      pad_in = '0;
      settle();
      bus_read(8'h40, 32'h0, "R11 no status without enables word 0");
      bus_read(8'h44, 32'h0, "R11 no status without enables word 1");

      // R7 rising on pin 5, falling on pin 40
      bus_write(8'h4C, 32'h0000_0020);
      @(negedge clk); pad_in[5] = 1'b1;
      settle();
      bus_read(8'h40, 32'h0000_0020, "R7 rising edge sets pin 5");
      pad_in[40] = 1'b1;
      settle();
      bus_write(8'h5C, 32'h0000_0100);
      @(negedge clk); pad_in[40] = 1'b0;
      settle();
      bus_read(8'h44, 32'h0000_0100, "R7 falling edge sets pin 40");

      // R9 write-one-to-clear
      bus_write(8'h40, 32'h0);
      settle();
      bus_read(8'h40, 32'h0000_0020, "R9 writing zero keeps status");
      bus_write(8'h40, 32'h0000_0020);
      bus_write(8'h44, 32'h0000_0100);
      settle();
      bus_read(8'h40, 32'h0, "R9 clear pin 5");
      bus_read(8'h44, 32'h0, "R9 clear pin 40");

      // R8 high-level on pin 7, sticky after removal
      bus_write(8'h64, 32'h0000_0080);
      @(negedge clk); pad_in[7] = 1'b1;
      settle();
      bus_read(8'h40, 32'h0000_0080, "R8 high level sets pin 7");
      bus_write(8'h40, 32'h0000_0080);
      settle();
      bus_read(8'h40, 32'h0000_0080, "R9 active detection beats clear");
      bus_write(8'h64, 32'h0);
      pad_in[7] = 1'b0;
      settle();
      bus_read(8'h40, 32'h0000_0080, "R8 status sticky after condition gone");
      bus_write(8'h40, 32'h0000_0080);
      settle();
      bus_read(8'h40, 32'h0, "R9 clear after detection stopped");

      // R8 low-level on pin 33
      bus_write(8'h74, 32'h0000_0002);
      settle();
      bus_read(8'h44, 32'h0000_0002, "R8 low level sets pin 33");
      bus_write(8'h74, 32'h0);
      bus_write(8'h44, 32'h0000_0002);
      settle();
      bus_read(8'h44, 32'h0, "R9 clear pin 33");

      // R10 nonexistent pins ignore writes
      bus_write(8'h50, 32'hFFFF_FFFF);
      bus_read(8'h50, 32'h003F_FFFF, "R10 rising word 1 upper bits zero");
      bus_write(8'h50, 32'h0);
      bus_read(8'h70, 32'h0, "R10 low enable word 0 untouched");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R12 missing read data actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule